// File: doc/BRIEF.md
# Exception Priority Masking Gate

This block stands between the interrupt arbiter's winning candidate and the core's request to take an exception. It holds three software-writable mask registers and decides, in the same cycle, whether the presented candidate may be taken. The three registers are:

- a one-bit global mask for configurable-priority interrupts;
- a one-bit fault mask;
- an 8-bit base-priority threshold.

Each mask has its own exemption rule. The non-maskable interrupt is exempt from all three masks. Fixed-priority faults are exempt from the global mask and from the threshold. Neither exemption applies to configurable-priority candidates.

The qualified request is combinational from the candidate and the current register contents. Software writes the registers through a simple write port that carries the 8-bit field. It reads them back through a registered 32-bit read port, on which reserved bits read as zero.

Top module: `prio_mask_gate`

## Requirements
- R1: After reset all three mask registers are zero. Every address reads back 0, and `take_req` equals `cand_valid` for any class and priority.
- R2: When the global mask bit (address 0, bit 0) is 1, a configurable candidate (`cand_class` 2'b00 or 2'b11) is blocked. Fault (2'b01) and NMI (2'b10) candidates are unaffected.
- R3: When the fault mask bit (address 1, bit 0) is 1, every candidate except NMI is blocked.
- R4: A nonzero threshold (address 2, bits [7:0]) blocks a configurable candidate whose priority is numerically greater than or equal to it. A zero threshold blocks nothing, and fault candidates ignore the threshold.
- R5: An NMI candidate is never blocked, whatever the mask registers hold.
- R6: The threshold is compared exactly as written, with no shift. A value of 0x20 blocks priority 0x20 and passes priority 0x1F.
- R7: `rd_data` shows the register selected by `rd_addr` one clock later. Bits [31:1] of both mask registers and bits [31:8] of the threshold read as zero, and address 3 reads as zero.
- R8: A write changes the decision from the clock edge that captures it onward. `take_req` reacts to candidate changes with no clock delay.
- R9: A write to address 3 changes no mask register.
- R10: `take_req` is 0 whenever `cand_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 global mask, 1 fault mask, 2 threshold |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read-back data |
| cand_valid | input | 1 | Arbiter candidate present |
| cand_class | input | 2 | 00/11 configurable, 01 fault, 10 NMI |
| cand_prio | input | 8 | Candidate priority, lower value is more urgent |
| take_req | output | 1 | Qualified take request |

## Verification
A vector table pairs each mask setting with each candidate class. This separates a gate that applies a mask to the wrong class from one that applies it correctly. Threshold vectors sit one below, at, and one above the threshold. They catch comparisons that are strict where they should not be, or that shift the value. Directed tests cover the following:
- write-to-decision timing;
- read-back zeroing of reserved bits;
- writes to the unused address;
- an idle candidate.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
  typedef enum logic [1:0] {
    CLS_CFG  = 2'b00,
    CLS_FLT  = 2'b01,
    CLS_NMI  = 2'b10,
    CLS_CFG2 = 2'b11
  } cand_class_e;

  typedef enum logic [1:0] {
    ADDR_GMASK = 2'd0,
    ADDR_FMASK = 2'd1,
    ADDR_THR   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic is_nmi;
    logic is_flt;
    logic is_cfg;
  } class_dec_t;
endpackage

// File: rtl/pmg_class_decode.sv
module pmg_class_decode
  import pmg_pkg::*;
#(
  parameter int CLS_W = 2
) (
  input  logic [CLS_W-1:0] cls,
  output class_dec_t       dec
);
  always_comb begin
    dec = '0;
    unique case (cls)
      CLS_NMI: dec.is_nmi = 1'b1;
      CLS_FLT: dec.is_flt = 1'b1;
      default: dec.is_cfg = 1'b1;
    endcase
  end
endmodule

// File: rtl/pmg_mask_regs.sv
module pmg_mask_regs
  import pmg_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              gmask,
  output logic              fmask,
  output logic [PRIO_W-1:0] thr
);
  localparam int PAD_W = DATA_W - PRIO_W;

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask <= 1'b0;
      fmask <= 1'b0;
      thr   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(ADDR_GMASK): gmask <= wr_data[0];
        ADDR_W'(ADDR_FMASK): fmask <= wr_data[0];
        ADDR_W'(ADDR_THR):   thr   <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(ADDR_GMASK): rd_mux[0] = gmask;
      ADDR_W'(ADDR_FMASK): rd_mux[0] = fmask;
      ADDR_W'(ADDR_THR):   rd_mux    = {{PAD_W{1'b0}}, thr};
      default:             rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pmg_mask_decide.sv
module pmg_mask_decide
  import pmg_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              cand_valid,
  input  class_dec_t        dec,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              gmask,
  input  logic              fmask,
  input  logic [PRIO_W-1:0] thr,
  output logic              take
);
  logic thr_hit;
  logic blk_global;
  logic blk_fault;
  logic blk_thr;

  always_comb begin
    thr_hit    = (thr != '0) && (cand_prio >= thr);
    blk_global = gmask && dec.is_cfg;
    blk_fault  = fmask && !dec.is_nmi;
    blk_thr    = thr_hit && dec.is_cfg;
    take       = cand_valid && (dec.is_nmi || !(blk_global || blk_fault || blk_thr));
  end
endmodule

// File: rtl/prio_mask_gate.sv
module prio_mask_gate
  import pmg_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CLS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cand_valid,
  input  logic [CLS_W-1:0]  cand_class,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              take_req
);
  logic              gmask_q;
  logic              fmask_q;
  logic [PRIO_W-1:0] thr_q;
  class_dec_t        cls_dec;

  pmg_mask_regs #(.PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .gmask(gmask_q), .fmask(fmask_q), .thr(thr_q)
  );

  pmg_class_decode #(.CLS_W(CLS_W)) u_dec (
    .cls(cand_class), .dec(cls_dec)
  );

  pmg_mask_decide #(.PRIO_W(PRIO_W)) u_decide (
    .cand_valid(cand_valid), .dec(cls_dec), .cand_prio(cand_prio),
    .gmask(gmask_q), .fmask(fmask_q), .thr(thr_q), .take(take_req)
  );
endmodule

// File: rtl/pmg_checker.sv
module pmg_checker #(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CLS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PRIO_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              cand_valid,
  input logic [CLS_W-1:0]  cand_class,
  input logic [PRIO_W-1:0] cand_prio,
  input logic              take_req,
  input logic              gmask,
  input logic              fmask,
  input logic [PRIO_W-1:0] thr
);
  logic is_cfg;
  assign is_cfg = (cand_class == 2'b00) || (cand_class == 2'b11);

  assert_nmi_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && cand_class == 2'b10) |-> take_req);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |-> !take_req);

  assert_global_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (gmask && is_cfg) |-> !take_req);

  assert_fault_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (fmask && cand_class != 2'b10) |-> !take_req);

  assert_threshold_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (thr != '0 && is_cfg && cand_prio >= thr) |-> !take_req);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:PRIO_W] == '0);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(1)) |=> (fmask == $past(wr_data[0])));

  assert_dead_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(3)) |=> $stable(thr));
endmodule

bind prio_mask_gate pmg_checker #(
  .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLS_W(CLS_W)
) u_pmg_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_data(rd_data), .cand_valid(cand_valid), .cand_class(cand_class),
  .cand_prio(cand_prio), .take_req(take_req),
  .gmask(gmask_q), .fmask(fmask_q), .thr(thr_q)
);

// File: tb/test_prio_mask_gate.sv
`timescale 1ns/1ps
module test_prio_mask_gate;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        cand_valid;
  logic [1:0]  cand_class;
  logic [7:0]  cand_prio;
  logic        take_req;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_mask_gate i_prio_mask_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cand_valid(cand_valid),
    .cand_class(cand_class), .cand_prio(cand_prio), .take_req(take_req)
  );

  // {gmask, fmask, thr[7:0], class[1:0], prio[7:0], expected take}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 2'b00, 8'hFF, 1'b1},  // R1 no masks
    {1'b1, 1'b0, 8'h00, 2'b00, 8'h00, 1'b0},  // R2 cfg blocked
    {1'b1, 1'b0, 8'h00, 2'b01, 8'h00, 1'b1},  // R2 fault passes
    {1'b1, 1'b0, 8'h00, 2'b10, 8'h00, 1'b1},  // R2 nmi passes
    {1'b0, 1'b1, 8'h00, 2'b00, 8'h00, 1'b0},  // R3 cfg blocked
    {1'b0, 1'b1, 8'h00, 2'b01, 8'h00, 1'b0},  // R3 fault blocked
    {1'b0, 1'b1, 8'h00, 2'b10, 8'h00, 1'b1},  // R3 nmi passes
    {1'b0, 1'b0, 8'h20, 2'b00, 8'h20, 1'b0},  // R6 equal blocked
    {1'b0, 1'b0, 8'h20, 2'b00, 8'h1F, 1'b1},  // R6 below passes
    {1'b0, 1'b0, 8'h20, 2'b00, 8'h21, 1'b0},  // R4 above blocked
    {1'b0, 1'b0, 8'h20, 2'b01, 8'hFF, 1'b1},  // R4 fault ignores thr
    {1'b0, 1'b0, 8'h01, 2'b00, 8'h00, 1'b1},  // R4 prio 0 passes
    {1'b0, 1'b0, 8'h01, 2'b00, 8'h01, 1'b0},  // R4 min thr
    {1'b0, 1'b0, 8'h00, 2'b00, 8'hFF, 1'b1},  // R4 zero thr disabled
    {1'b0, 1'b0, 8'h80, 2'b11, 8'h80, 1'b0},  // R4 class 11 is cfg
    {1'b1, 1'b1, 8'hFF, 2'b10, 8'hFF, 1'b1},  // R5 all masks, nmi
    {1'b0, 1'b0, 8'h20, 2'b10, 8'hFF, 1'b1}   // R5 nmi vs thr
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cand_valid = 1'b0; cand_class = '0; cand_prio = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_check("R1", 2'd0, 32'h0);
    rd_check("R1", 2'd1, 32'h0);
    rd_check("R1", 2'd2, 32'h0);
    cand_valid = 1'b1; cand_class = 2'b00; cand_prio = 8'hFF; #1;
    check("R1", {31'b0, take_req}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {7'b0, VEC[i][20]});
      wr(2'd1, {7'b0, VEC[i][19]});
      wr(2'd2, VEC[i][18:11]);
      cand_valid = 1'b1; cand_class = VEC[i][10:9]; cand_prio = VEC[i][8:1];
      #1;
      check($sformatf("vector %0d R2-group", i), {31'b0, take_req}, {31'b0, VEC[i][0]});
    end

    // R7 read-back, reserved bits zero
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFE);
    wr(2'd2, 8'hA5);
    rd_check("R7", 2'd0, 32'h1);
    rd_check("R7", 2'd1, 32'h0);
    rd_check("R7", 2'd2, 32'hA5);
    rd_check("R7", 2'd3, 32'h0);

    // R9 write to address 3 has no effect
    wr(2'd3, 8'h00);
    rd_check("R9", 2'd0, 32'h1);
    rd_check("R9", 2'd2, 32'hA5);

    // R10 idle candidate, with no masks and an NMI class
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    cand_valid = 1'b0; cand_class = 2'b10; #1;
    check("R10", {31'b0, take_req}, 32'h0);

    // R8 write lands at the next edge; candidate change reacts at once
    cand_valid = 1'b1; cand_class = 2'b00; cand_prio = 8'h10; #1;
    check("R8", {31'b0, take_req}, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h01; #1;
    check("R8 before edge", {31'b0, take_req}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R8 after edge", {31'b0, take_req}, 32'h0);
    cand_class = 2'b10; #1;
    check("R8 comb", {31'b0, take_req}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule